// File: doc/BRIEF.md
# Receive Character Queue with Line Status

This block sits between a UART receiver and the host-facing register file. Every character the receiver finishes arrives on a push port with three error flags: break, framing and parity. The character and its flags are stored together as one queue entry. The host reads the oldest character through a data-register read strobe, which also pops it. A separate status read shows a status byte that describes the oldest character and the queue as a whole, without removing anything.

The status byte holds several kinds of information:
- whether the queue has data;
- a sticky overrun indication;
- the error flags of the entry at the head;
- a summary bit that is set while any stored entry is erroneous.

It also passes through two transmit-side empty indications. A counter of erroneous entries drives the summary bit, so no search over the storage is needed.

Top module: `rx_line_fifo`

## Requirements
- R1: The queue holds up to DEPTH (default 64) entries. A push while not full is accepted, and characters leave in the order they were pushed, shown on `head_data`.
- R2: Status bit 4 shows the break flag of the head entry, bit 3 its framing flag and bit 2 its parity flag. These bits follow the head entry as entries are popped.
- R3: Status bit 0 is 1 while at least one entry is stored. When the queue is empty, bits 4:2 read 0.
- R4: Status bit 7 is 1 while any stored entry has at least one flag set, and 0 once none remains. This holds when a push and a pop happen in the same cycle.
- R5: A status read (`stat_rd`) never removes an entry. Only `data_rd` pops.
- R6: A pushed character with the break flag set is stored as 0x00, whatever its data input.
- R7: A push while full is discarded and sets the overrun flag. The flag is shown on `overrun` and on status bit 1.
- R8: A status read clears the overrun flag in the following cycle. If a discarded push happens in the same cycle, the flag stays set.
- R9: A `data_rd` on an empty queue changes nothing, and `head_data` keeps the last popped character.
- R10: Status bit 5 equals `thr_empty` and status bit 6 equals `tx_all_empty`, with no delay.
- R11: After reset the queue is empty, the error count and overrun flag are 0, and `head_data` is 0x00. With both transmit inputs high, the status byte reads 0x60.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| push_valid | input | 1 | Receiver presents a finished character |
| push_data | input | 8 | Received character |
| push_brk | input | 1 | Break flag of the character |
| push_frm | input | 1 | Framing error flag |
| push_par | input | 1 | Parity error flag |
| data_rd | input | 1 | Data-register read; pops the head entry |
| stat_rd | input | 1 | Status read; clears overrun |
| thr_empty | input | 1 | Transmit holding register empty |
| tx_all_empty | input | 1 | Transmit holding and shift registers both empty |
| head_data | output | 8 | Head character, or last popped one when empty |
| status | output | 8 | Line status byte |
| overrun | output | 1 | Sticky overrun flag |

## Verification
A wrong pointer or occupancy count shows up at once on `head_data` and on status bit 0. Such an error puts characters out of order, repeats them or loses them on the next pop. A drifting error count shows up on status bit 7, possibly many pops later when the queue drains and the bit fails to fall. The bench therefore drains the queue completely after each mixed sequence. It also checks every status field before each cycle against a queue model. A fault in the flag storage shows up on bits 4:2 as soon as the affected entry reaches the head.

// File: rtl/rxlf_pkg.sv
package rxlf_pkg;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_flags_t;

  typedef struct packed {
    rx_flags_t  flags;
    logic [7:0] data;
  } rx_entry_t;

  function automatic logic flags_bad(rx_flags_t f);
    return f.brk | f.frm | f.par;
  endfunction

endpackage

// File: rtl/rxlf_store.sv
module rxlf_store
  import rxlf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_ok,
  input  logic            pop_ok,
  input  rx_entry_t       wr_entry,
  output rx_entry_t       head_entry,
  output logic [7:0]      last_data,
  output logic [CW-1:0]   count,
  output logic            empty,
  output logic            full
);

  rx_entry_t mem [DEPTH];

  logic [AW-1:0] wr_ptr, wr_ptr_nx;
  logic [AW-1:0] rd_ptr, rd_ptr_nx;
  logic [CW-1:0] count_nx;
  logic [7:0]    last_nx;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));

  always_comb begin
    wr_ptr_nx = wr_ptr;
    rd_ptr_nx = rd_ptr;
    count_nx  = count;
    last_nx   = last_data;
    if (push_ok) begin
      wr_ptr_nx = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
    end
    if (pop_ok) begin
      rd_ptr_nx = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      last_nx   = mem[rd_ptr].data;
    end
    case ({push_ok, pop_ok})
      2'b10:   count_nx = count + 1'b1;
      2'b01:   count_nx = count - 1'b1;
      default: count_nx = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      last_data <= '0;
    end else begin
      wr_ptr    <= wr_ptr_nx;
      rd_ptr    <= rd_ptr_nx;
      count     <= count_nx;
      last_data <= last_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem[wr_ptr] <= wr_entry;
    end
  end

  assign head_entry = mem[rd_ptr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R1

  AST_PTR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (count != CW'(DEPTH)) |-> (AW'(wr_ptr - rd_ptr) == count[AW-1:0])); // R1

endmodule

// File: rtl/rxlf_err_track.sv
module rxlf_err_track #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_ok,
  input  logic          push_bad,
  input  logic          pop_ok,
  input  logic          pop_bad,
  input  logic [CW-1:0] count,
  output logic          any_err
);

  logic [CW-1:0] errcnt, errcnt_nx;
  logic          inc, dec;

  assign inc = push_ok & push_bad;
  assign dec = pop_ok & pop_bad;

  always_comb begin
    case ({inc, dec})
      2'b10:   errcnt_nx = errcnt + 1'b1;
      2'b01:   errcnt_nx = errcnt - 1'b1;
      default: errcnt_nx = errcnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) errcnt <= '0;
    else        errcnt <= errcnt_nx;
  end

  assign any_err = (errcnt != '0);

  AST_ERR_WITHIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    errcnt <= count); // R4

  AST_ERR_CLEAR_ON_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !any_err); // R4

endmodule

// File: rtl/rxlf_status.sv
module rxlf_status
  import rxlf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push_drop,
  input  logic      stat_rd,
  input  logic      empty,
  input  rx_flags_t head_flags,
  input  logic      any_err,
  input  logic      thr_empty,
  input  logic      tx_all_empty,
  output logic      overrun,
  output logic [7:0] status
);

  logic      ovr_nx;
  rx_flags_t shown;

  always_comb begin
    ovr_nx = overrun;
    if (stat_rd)   ovr_nx = 1'b0;
    if (push_drop) ovr_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overrun <= 1'b0;
    else        overrun <= ovr_nx;
  end

  assign shown  = empty ? '0 : head_flags;
  assign status = {any_err, tx_all_empty, thr_empty,
                   shown.brk, shown.frm, shown.par, overrun, ~empty};

  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> overrun); // R7

  AST_OVR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !push_drop) |=> !overrun); // R8

  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rd && !push_drop) |=> (overrun == $past(overrun))); // R7

endmodule

// File: rtl/rx_line_fifo.sv
module rx_line_fifo
  import rxlf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_valid,
  input  logic [7:0] push_data,
  input  logic       push_brk,
  input  logic       push_frm,
  input  logic       push_par,
  input  logic       data_rd,
  input  logic       stat_rd,
  input  logic       thr_empty,
  input  logic       tx_all_empty,
  output logic [7:0] head_data,
  output logic [7:0] status,
  output logic       overrun
);

  rx_entry_t     wr_entry, head_entry;
  logic [7:0]    last_data;
  logic [CW-1:0] count;
  logic          empty, full;
  logic          push_ok, pop_ok, push_drop;
  logic          any_err;

  assign push_ok   = push_valid & ~full;
  assign push_drop = push_valid & full;
  assign pop_ok    = data_rd & ~empty;

  always_comb begin
    wr_entry.flags.brk = push_brk;
    wr_entry.flags.frm = push_frm;
    wr_entry.flags.par = push_par;
    wr_entry.data      = push_brk ? 8'h00 : push_data;
  end

  rxlf_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_ok    (push_ok),
    .pop_ok     (pop_ok),
    .wr_entry   (wr_entry),
    .head_entry (head_entry),
    .last_data  (last_data),
    .count      (count),
    .empty      (empty),
    .full       (full)
  );

  rxlf_err_track #(.CW(CW)) u_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_ok  (push_ok),
    .push_bad (flags_bad(wr_entry.flags)),
    .pop_ok   (pop_ok),
    .pop_bad  (flags_bad(head_entry.flags)),
    .count    (count),
    .any_err  (any_err)
  );

  rxlf_status u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_drop    (push_drop),
    .stat_rd      (stat_rd),
    .empty        (empty),
    .head_flags   (head_entry.flags),
    .any_err      (any_err),
    .thr_empty    (thr_empty),
    .tx_all_empty (tx_all_empty),
    .overrun      (overrun),
    .status       (status)
  );

  assign head_data = empty ? last_data : head_entry.data;

  AST_STAT_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !data_rd) |=> (count >= $past(count))); // R5

  AST_FULL_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && full && !data_rd) |=> (count == $past(count))); // R7

  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && empty && !push_valid) |=> (empty && $stable(head_data))); // R9

  AST_BREAK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && push_valid && push_brk) |=> (head_data == 8'h00 && status[4])); // R6

endmodule

// File: tb/test_rx_line_fifo.sv
module test_rx_line_fifo;

  localparam int DEPTH = 64;

  logic       clk, rst_n;
  logic       push_valid, push_brk, push_frm, push_par;
  logic [7:0] push_data;
  logic       data_rd, stat_rd, thr_empty, tx_all_empty;
  logic [7:0] head_data, status;
  logic       overrun;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [10:0] exp_q[$];
  logic [7:0]  m_last = 8'h00;
  logic        m_ovr  = 1'b0;

  rx_line_fifo #(.DEPTH(DEPTH)) i_rx_line_fifo (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .push_brk(push_brk), .push_frm(push_frm), .push_par(push_par),
    .data_rd(data_rd), .stat_rd(stat_rd), .thr_empty(thr_empty),
    .tx_all_empty(tx_all_empty), .head_data(head_data), .status(status),
    .overrun(overrun)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] exp_status();
    logic any;
    logic [2:0] fl;
    any = 1'b0;
    foreach (exp_q[i]) if (exp_q[i][10:8] != 3'b000) any = 1'b1;
    fl = (exp_q.size() > 0) ? exp_q[0][10:8] : 3'b000;
    return {any, tx_all_empty, thr_empty, fl, m_ovr, exp_q.size() > 0};
  endfunction

  function automatic logic [7:0] exp_head();
    return (exp_q.size() > 0) ? exp_q[0][7:0] : m_last;
  endfunction

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Monitor: compares the ports with the model queue before each edge.
  task automatic monitor(string tag);
    #1;
    check8({tag, " status"}, status, exp_status());
    check8({tag, " head"}, head_data, exp_head());
    check8({tag, " overrun"}, {7'd0, overrun}, {7'd0, m_ovr});
  endtask

  // Driver: applies one cycle and updates the model queue.
  task automatic step(string tag, bit psh, logic [7:0] d, logic [2:0] fl,
                      bit rd, bit srd);
    bit was_full;
    push_valid = psh; push_data = d;
    {push_brk, push_frm, push_par} = fl;
    data_rd = rd; stat_rd = srd;
    monitor(tag);
    was_full = (exp_q.size() >= DEPTH);
    if (rd && exp_q.size() > 0) m_last = exp_q.pop_front() & 8'hFF;
    if (srd) m_ovr = 1'b0;
    if (psh) begin
      if (was_full) m_ovr = 1'b1;
      else exp_q.push_back({fl, fl[2] ? 8'h00 : d});
    end
    @(negedge clk);
    push_valid = 0; data_rd = 0; stat_rd = 0;
  endtask

  task automatic drain(string tag);
    while (exp_q.size() > 0) step(tag, 0, 8'h00, 3'b000, 1, 0);
    monitor(tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; push_valid = 0; push_data = 0; push_brk = 0; push_frm = 0;
    push_par = 0; data_rd = 0; stat_rd = 0; thr_empty = 1; tx_all_empty = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11: reset state
    #1;
    check8("R11 reset status", status, 8'h60);
    check8("R11 reset head", head_data, 8'h00);
    @(negedge clk);

    // R10: transmit passthrough
    thr_empty = 1; tx_all_empty = 0; monitor("R10 thr only");
    thr_empty = 0; tx_all_empty = 0; monitor("R10 none");
    thr_empty = 1; tx_all_empty = 1;

    // R1, R2, R3: ordered pushes, flags follow the head
    step("R1 push a", 1, 8'hA1, 3'b000, 0, 0);
    step("R2 push frm", 1, 8'hB2, 3'b010, 0, 0);
    step("R2 push par", 1, 8'hC3, 3'b001, 0, 0);
    step("R1 push d", 1, 8'hD4, 3'b000, 0, 0);
    // R5: status reads do not pop
    step("R5 stat read", 0, 8'h00, 3'b000, 0, 1);
    step("R5 stat read", 0, 8'h00, 3'b000, 0, 1);
    // R6: break forced to zero
    step("R6 push break", 1, 8'h5A, 3'b100, 0, 0);
    // R4: simultaneous push and pop
    step("R4 push+pop", 1, 8'hE5, 3'b000, 1, 0);
    step("R4 push+pop err", 1, 8'hF6, 3'b011, 1, 0);
    step("R4 pop err", 0, 8'h00, 3'b000, 1, 0);
    drain("R4 drain");
    // R3, R9: empty reads keep the last value
    step("R9 empty read", 0, 8'h00, 3'b000, 1, 0);
    step("R9 empty read", 0, 8'h00, 3'b000, 1, 0);
    monitor("R3 empty");

    // R7: fill and overflow
    for (int i = 0; i < DEPTH; i++)
      step("R1 fill", 1, 8'(i * 7 + 3), (i == 5) ? 3'b010 : 3'b000, 0, 0);
    step("R7 overflow", 1, 8'h99, 3'b001, 0, 0);
    step("R7 overflow again", 1, 8'h98, 3'b000, 0, 0);
    // R8: clear loses to a discarded push in the same cycle
    step("R8 clear+drop", 1, 8'h97, 3'b000, 0, 1);
    step("R8 clear", 0, 8'h00, 3'b000, 0, 1);
    step("R8 after clear", 0, 8'h00, 3'b000, 0, 0);
    // R7: pop on full with push, push is discarded
    step("R7 full push+pop", 1, 8'h96, 3'b000, 1, 0);
    drain("R1 drain full");
    step("R9 empty after drain", 0, 8'h00, 3'b000, 1, 0);
    monitor("R3 final");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule